// File: doc/BRIEF.md
# Dual Dedicated-Line Interrupt Cell

This cell raises two interrupt requests on two request lines that belong to it alone. Nothing else shares the lines and there is no priority chain through neighbouring devices. Line 1 carries an interrupt taken from an external stimulus, and that stimulus's active level is set by a parameter. Line 2 carries the end-of-block interrupt, raised by the processor's echo pulse. Each line has an enable flag, which select function codes set and clear, and a capture flag that drives its request line directly.

The processor acknowledges an interrupt with an address-request phase followed by a pulse strobe. Three system interrupts rank above both lines. While one of them is being serviced, it pulls a monitored data-bus bit low during the address-request phase. The cell watches that bit. It withdraws a request only when the bit stayed high for the whole phase up to the strobe, which means the request was really honored. Line 1 always goes first. Line 2 is released only on an honored acknowledge during which line 1 is not pending.

Top module: `irq_dual_line`

## Requirements
- R1: After a synchronous reset, or a cycle with `init_i` high, both request lines and both enable flags are cleared. A stimulus edge that follows therefore raises no request.
- R2: When `sel_valid_i` is high, select code FC_BASE+0 sets the line 1 enable and FC_BASE+1 clears it. FC_BASE+2 sets the line 2 enable and FC_BASE+3 clears it (codes 8, 9, 10 and 11 by default). Codes are ignored while `sel_valid_i` is low. An enable takes effect from the next cycle.
- R3: While line 1 is enabled, a change of `stim_i` from its inactive level to its active level (active high when STIM_ACT_HIGH is 1, active low when it is 0) sets `req_o[0]` at the clock edge that samples the active level.
- R4: While line 2 is enabled, a rising edge of `echo_i` sets `req_o[1]` at the clock edge that samples it high.
- R5: A stimulus or echo that stays active after its request has been serviced does not raise the request again. A fresh change from inactive to active is needed.
- R6: An activating edge that arrives while its line is disabled is ignored. Enabling the line later, while the source is still active, raises no request.
- R7: The leading edge of `strobe_i` while `addr_req_i` is high clears the highest-ranked pending line, provided `dbus_mon_i` was high on every sampled cycle of the current address-request phase, including the strobe cycle. The request falls at the clock edge that samples the strobe's first high cycle.
- R8: If `dbus_mon_i` is sampled low on any cycle of an address-request phase up to and including the strobe cycle, no request clears in that phase. The preemption memory ends when `addr_req_i` falls.
- R9: When both lines are pending, `req_o[0]` clears first. `req_o[1]` clears only on a later honored strobe while `req_o[0]` is low.
- R10: A strobe that stays high for several cycles clears at most one line. A strobe outside an address-request phase clears nothing.
- R11: Clearing a line's enable does not withdraw a request already captured on that line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Initialize: clears enables and requests |
| stim_i | input | 1 | External stimulus for line 1, polarity set by STIM_ACT_HIGH |
| echo_i | input | 1 | Processor echo pulse, end-of-block source for line 2 |
| sel_valid_i | input | 1 | Addressed select command strobe |
| sel_code_i | input | FC_W | Select function code |
| addr_req_i | input | 1 | Processor address-request phase |
| dbus_mon_i | input | 1 | Monitored data-bus bit, low while a higher-ranked system interrupt is served |
| strobe_i | input | 1 | Processor pulse strobe |
| req_o | output | 2 | Request lines: bit 0 is line 1, bit 1 is line 2 (active high) |

## Verification
The bench builds the cell with STIM_ACT_HIGH at 0, FC_W at 4 and FC_BASE at 8. The stimulus is therefore active low and idles high through reset. This exercises the inverted capture path and shows that an idle-high source produces no false capture when reset releases. With these select codes, set and clear commands for both lines can be interleaved with captures. Using them, the vector walk covers the following:
- stacking both lines;
- preemption seen early in a phase and in the strobe cycle itself;
- held strobes;
- disabled edges;
- a held source that must not capture again after service.

// File: rtl/irq_dl_pkg.sv
// Package: shared constants and helpers for the dual dedicated-line
// interrupt cell. Assumes exactly two request lines, index 0 ranked higher.
package irq_dl_pkg;

    localparam int NLINES = 2;

    typedef logic [NLINES-1:0] line_vec_t;

    // Returns a one-hot vector of the lowest-index (highest-ranked) set bit.
    function automatic line_vec_t first_pending(input line_vec_t v);
        line_vec_t r;
        r = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                r = '0;
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_sel_decode.sv
// Module: decodes addressed select commands into per-line enable set and
// clear strobes. Line i owns codes FC_BASE+2i (set) and FC_BASE+2i+1 (clear).
// Assumes FC_BASE + 2*NLINES fits in FC_W bits. Purely combinational.
module irq_sel_decode
    import irq_dl_pkg::*;
#(
    parameter int FC_W    = 4,
    parameter int FC_BASE = 8
) (
    input  logic            sel_valid_i,
    input  logic [FC_W-1:0] sel_code_i,
    output line_vec_t       en_set_o,
    output line_vec_t       en_clr_o
);

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        localparam logic [FC_W-1:0] CODE_SET = FC_W'(FC_BASE + 2 * g);
        localparam logic [FC_W-1:0] CODE_CLR = FC_W'(FC_BASE + 2 * g + 1);

        // Match this line's two function codes when a select is valid.
        always_comb begin
            en_set_o[g] = sel_valid_i && (sel_code_i == CODE_SET);
            en_clr_o[g] = sel_valid_i && (sel_code_i == CODE_CLR);
        end
    end

endmodule

// File: rtl/irq_line_capture.sv
// Module: one interrupt line. It holds the enable flag, an edge detector on
// the (already active-high) source and the capture flag that drives the
// request line. Capture needs an inactive-to-active transition, so a source
// held active does not capture again. A capture edge wins over a service
// clear in the same cycle. Init clears everything.
module irq_line_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic src_act_i,
    input  logic en_set_i,
    input  logic en_clr_i,
    input  logic svc_clr_i,
    output logic pend_o
);

    logic act_q;
    logic en_q;
    logic flag_q;
    logic edge_w;

    assign edge_w = src_act_i && !act_q;
    assign pend_o = flag_q;

    // Remember the previous source level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= src_act_i;
    end

    // Enable flag: set and cleared by select decodes, cleared by init.
    always_ff @(posedge clk) begin
        if (!rst_n || init_i) en_q <= 1'b0;
        else if (en_clr_i)    en_q <= 1'b0;
        else if (en_set_i)    en_q <= 1'b1;
    end

    // Capture flag: set on an enabled edge, cleared when serviced.
    always_ff @(posedge clk) begin
        if (!rst_n || init_i)     flag_q <= 1'b0;
        else if (edge_w && en_q)  flag_q <= 1'b1;
        else if (svc_clr_i)       flag_q <= 1'b0;
    end

    AST_CAPTURE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(en_q)); // R6

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && act_q && src_act_i) |=> !flag_q); // R5

    AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set_i && !en_clr_i && !init_i) |=> en_q); // R2

    AST_DISABLE_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && en_clr_i && !svc_clr_i && !init_i) |=> flag_q); // R11

endmodule

// File: rtl/irq_service_ctrl.sv
// Module: decides when a pending request was honored. It tracks whether the
// monitored data-bus bit went low during the current address-request phase
// and detects the strobe's leading edge. On an honored acknowledge it emits
// a one-hot clear for the highest-ranked pending line. Assumes addr_req_i
// stays high across the strobe of one acknowledge.
module irq_service_ctrl
    import irq_dl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      init_i,
    input  line_vec_t pend_i,
    input  logic      addr_req_i,
    input  logic      dbus_mon_i,
    input  logic      strobe_i,
    output line_vec_t clr_o
);

    logic strb_q;
    logic preempt_q;
    logic lead_w;
    logic honored_w;

    assign lead_w    = strobe_i && !strb_q;
    assign honored_w = lead_w && addr_req_i && dbus_mon_i && !preempt_q;

    // Delayed strobe for leading-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strb_q <= 1'b0;
        else        strb_q <= strobe_i;
    end

    // Preemption memory: set by a low bus bit inside the phase, cleared between phases.
    always_ff @(posedge clk) begin
        if (!rst_n || init_i || !addr_req_i) preempt_q <= 1'b0;
        else if (!dbus_mon_i)                preempt_q <= 1'b1;
    end

    // Pick the highest-ranked pending line on an honored acknowledge.
    always_comb begin
        clr_o = honored_w ? first_pending(pend_i) : '0;
    end

    AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_o)); // R9

    AST_HELD_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && $past(strobe_i)) |-> (clr_o == '0)); // R10

    AST_NO_CLEAR_OUTSIDE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_req_i |-> (clr_o == '0)); // R10

    AST_PREEMPT_REMEMBERED: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_req_i && !dbus_mon_i && !init_i) |=> (addr_req_i |-> clr_o == '0)); // R8

endmodule

// File: rtl/irq_dual_line.sv
// Module (top): dual dedicated-line interrupt cell. Line 1 (req_o[0]) takes
// an external stimulus of programmable polarity. Line 2 (req_o[1]) takes the
// processor echo pulse. Requests stay up until an honored acknowledge, which
// is an address-request phase with the monitored bus bit high throughout and
// a strobe leading edge. Assumes all inputs are synchronous to clk.
module irq_dual_line
    import irq_dl_pkg::*;
#(
    parameter bit STIM_ACT_HIGH = 1'b1,
    parameter int FC_W          = 4,
    parameter int FC_BASE       = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init_i,
    input  logic            stim_i,
    input  logic            echo_i,
    input  logic            sel_valid_i,
    input  logic [FC_W-1:0] sel_code_i,
    input  logic            addr_req_i,
    input  logic            dbus_mon_i,
    input  logic            strobe_i,
    output logic [1:0]      req_o
);

    line_vec_t src_act;
    line_vec_t en_set;
    line_vec_t en_clr;
    line_vec_t svc_clr;
    line_vec_t pend;

    // Normalize sources to active high: line 1 per parameter, line 2 echo.
    always_comb begin
        src_act[0] = STIM_ACT_HIGH ? stim_i : !stim_i;
        src_act[1] = echo_i;
    end

    irq_sel_decode #(
        .FC_W    (FC_W),
        .FC_BASE (FC_BASE)
    ) u_dec (
        .sel_valid_i (sel_valid_i),
        .sel_code_i  (sel_code_i),
        .en_set_o    (en_set),
        .en_clr_o    (en_clr)
    );

    for (genvar g = 0; g < NLINES; g++) begin : g_cap
        irq_line_capture u_cap (
            .clk       (clk),
            .rst_n     (rst_n),
            .init_i    (init_i),
            .src_act_i (src_act[g]),
            .en_set_i  (en_set[g]),
            .en_clr_i  (en_clr[g]),
            .svc_clr_i (svc_clr[g]),
            .pend_o    (pend[g])
        );
    end

    irq_service_ctrl u_svc (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (init_i),
        .pend_i     (pend),
        .addr_req_i (addr_req_i),
        .dbus_mon_i (dbus_mon_i),
        .strobe_i   (strobe_i),
        .clr_o      (svc_clr)
    );

    assign req_o = pend;

    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (req_o == 2'b00)); // R1

    AST_PREEMPT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_req_i && !dbus_mon_i && !init_i) |=> ((req_o & $past(req_o)) == $past(req_o))); // R8

    AST_LINE1_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o == 2'b11 && !init_i) |=> req_o[1]); // R9

endmodule

// File: tb/sim_irq_dual_line.sv
// Bench: walks a vector table (one clock per vector, drive at the falling
// edge, check req_o at the next falling edge), then directed tests of init
// and reset. Stimulus is active low in this build.
module sim_irq_dual_line;

    localparam int FC_W = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            init_i = 1'b0;
    logic            stim_i = 1'b1;
    logic            echo_i = 1'b0;
    logic            sel_valid_i = 1'b0;
    logic [FC_W-1:0] sel_code_i = '0;
    logic            addr_req_i = 1'b0;
    logic            dbus_mon_i = 1'b1;
    logic            strobe_i = 1'b0;
    logic [1:0]      req_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = !clk; // 50 MHz

    irq_dual_line #(
        .STIM_ACT_HIGH (1'b0),
        .FC_W          (FC_W),
        .FC_BASE       (8)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (init_i),
        .stim_i      (stim_i),
        .echo_i      (echo_i),
        .sel_valid_i (sel_valid_i),
        .sel_code_i  (sel_code_i),
        .addr_req_i  (addr_req_i),
        .dbus_mon_i  (dbus_mon_i),
        .strobe_i    (strobe_i),
        .req_o       (req_o)
    );

    // Vector fields: [11] sel valid, [10:7] code, [6] stim active, [5] echo,
    // [4] addr req, [3] bus bit, [2] strobe, [1:0] expected req_o.
    localparam int NV = 32;
    localparam logic [11:0] VEC [NV] = '{
        {1'b1, 4'd8,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00}, // 0  R2 enable line 1
        {1'b1, 4'd10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00}, // 1  R2 enable line 2
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01}, // 2  R3 capture
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01}, // 3  R3 hold
        {1'b0, 4'd0,  1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11}, // 4  R4 echo
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b11}, // 5  R4 hold
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b11}, // 6  R7 phase open
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b10}, // 7  R9 line 1 first
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b10}, // 8  R10 held strobe
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10}, // 9  R5 held stim
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b10}, // 10 R8 bus low
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b10}, // 11 R8 remembered
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10}, // 12 R8 phase ends
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00}, // 13 R9 line 2 next
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00}, // 14 R5 no retrigger
        {1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00}, // 15 R5 release
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01}, // 16 R5 fresh edge
        {1'b1, 4'd9,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01}, // 17 R11 disable
        {1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01}, // 18 R11 still up
        {1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00}, // 19 R7 honored
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00}, // 20 R6 disabled edge
        {1'b1, 4'd8,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00}, // 21 R6 enable late
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00}, // 22 R6 no capture
        {1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00}, // 23 R3 release
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01}, // 24 R3 capture
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b01}, // 25 R10 strobe no phase
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01}, // 26 R10
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b01}, // 27 R8 low at strobe
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01}, // 28 R8
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00}, // 29 R7 honored
        {1'b0, 4'd9,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00}, // 30 R2 invalid select
        {1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01}  // 31 R2 still enabled
    };
    localparam int TAG [NV] = '{2, 2, 3, 3, 4, 4, 7, 9, 10, 5, 8, 8, 8, 9, 5, 5,
                                5, 11, 11, 7, 6, 6, 6, 3, 3, 10, 10, 8, 8, 7, 2, 2};

    task automatic check(input logic [1:0] exp, input string req);
        n_tests++;
        if (req_o !== exp) begin
            n_fail++;
            $display("FAIL %s: req_o=%b expected %b", req, req_o, exp);
        end
    endtask

    // One clock: drive now (at a falling edge), then wait to the next falling edge.
    task automatic step(input logic sv, input logic [FC_W-1:0] code, input logic stim_act,
                        input logic echo, input logic ar, input logic db, input logic stb);
        sel_valid_i = sv;
        sel_code_i  = code;
        stim_i      = !stim_act;
        echo_i      = echo;
        addr_req_i  = ar;
        dbus_mon_i  = db;
        strobe_i    = stb;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(2'b00, "R1 reset state");

        for (int i = 0; i < NV; i++) begin
            logic [11:0] v;
            v = VEC[i];
            step(v[11], v[10:7], v[6], v[5], v[4], v[3], v[2]);
            check(v[1:0], $sformatf("R%0d vector %0d", TAG[i], i));
        end

        // R1: init clears a pending request and both enables.
        init_i = 1'b1;
        step(0, 0, 1, 0, 0, 1, 0);
        init_i = 1'b0;
        check(2'b00, "R1 init clears request");
        step(0, 0, 0, 0, 0, 1, 0);
        step(0, 0, 1, 1, 0, 1, 0);
        check(2'b00, "R1 enables cleared by init");

        // R1: synchronous reset during operation.
        step(1, 4'd8, 0, 0, 0, 1, 0);
        step(0, 0, 1, 0, 0, 1, 0);
        check(2'b01, "R3 capture before reset");
        rst_n = 1'b0;
        step(0, 0, 1, 0, 0, 1, 0);
        rst_n = 1'b1;
        check(2'b00, "R1 reset clears request");
        step(0, 0, 0, 0, 0, 1, 0);
        step(0, 0, 1, 0, 0, 1, 0);
        check(2'b00, "R1 enable cleared by reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule